// File: doc/BRIEF.md
# Over-Current Protection Sequencer

This block is the digital protection controller that sits beside a half-bridge gate driver. It watches two over-current comparator flags (one per switch), two supply-undervoltage flags and the present on/off state of each gate. It produces one shutdown signal that forces both gate outputs off, and one status signal for a host. An external request input lets a host force a shutdown or clear a locked fault.

A saturating up/down counter stands in for the external timing capacitor. Its range is `FULL_SCALE`. There are two thresholds: the lower one is 30 % of full scale and the upper one is 70 %. In self-reset mode a fault discharges the counter. When the counter drops under the lower threshold the fault is cleared and charging starts. Switching resumes once the counter reaches the upper threshold. The same charge phase supplies the power-up delay. In latched mode a fault or a power-up holds the block in shutdown until the external request has been held for a minimum number of cycles and then released.

Each side's comparator flag passes through a two-flop synchronizer. It only counts while that side's gate is on and its blanking window after turn-on has expired.

Top module: `ocp_sequencer`

## Requirements
- R1: An accepted over-current flag sets the fault state on that clock edge, and `shutdown` is high after that edge.
- R2: In self-reset mode, after a fault the timer steps down by `STEP` each cycle, starting from its value at the trip. On the first edge where the timer is below `FULL_SCALE*30/100`, the fault clears and charging begins.
- R3: While charging, the block returns to normal operation on the first edge at which the timer is at least `FULL_SCALE*70/100`. The timer rises by `STEP` per cycle and saturates at `FULL_SCALE`.
- R4: The high-side flag is evaluated only while `hi_gate_on` is 1, and the low-side flag only while `lo_gate_on` is 1.
- R5: A side's flag is accepted at an edge only if that side's gate was on at that edge and at the `BLANK_CYC` edges before it. A shorter on-time never trips.
- R6: A raw flag rising while its side is armed trips the block at the third clock edge after the rise.
- R7: After reset in self-reset mode, `shutdown` is high and the timer charges from 0. Release follows the timing of R3.
- R8: In latched mode, a power-up, a fault or any `ext_reset` assertion leaves the block in shutdown. It leaves shutdown only on the first edge with `ext_reset` low after `ext_reset` was high for at least `MIN_RST_CYC` consecutive edges. Shorter pulses leave it in shutdown and leave the fault indication unchanged.
- R9: While either undervoltage flag is 1, `shutdown` is 1 in the same cycle. Once both flags are 0, the block restarts exactly as after reset.
- R10: In self-reset mode, `ext_reset` high clears the timer and the fault state and holds shutdown. After release, the block recharges as in R7.
- R11: If the over-current persists, each return to operation is followed by a new trip, with the same blanking and recovery times.
- R12: `prot_status` is 1 while a fault is held or the timer is discharging, and 0 during charge, during normal operation and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_oc_raw | input | 1 | High-side over-current comparator flag (unsynchronized) |
| lo_oc_raw | input | 1 | Low-side over-current comparator flag (unsynchronized) |
| hi_gate_on | input | 1 | High-side gate currently on |
| lo_gate_on | input | 1 | Low-side gate currently on |
| uv_logic | input | 1 | Logic-supply undervoltage flag |
| uv_drive | input | 1 | Gate-drive-supply undervoltage flag |
| latch_mode | input | 1 | 1 = latched protection, 0 = self-reset (static in use) |
| ext_reset | input | 1 | External shutdown / fault-clear request |
| shutdown | output | 1 | Forces both gate outputs off |
| prot_status | output | 1 | Protection event in progress |

## Verification
The hardest situations to reach are the boundaries of the blanking window and of the latched-mode reset pulse. Each differs by a single cycle between "ignored" and "acts". The bench holds a flag already synchronized and sweeps the gate on-time across the blanking length on each side. It sweeps `ext_reset` pulse widths from one cycle up past the minimum, both while locked and while running. Recovery lengths are predicted by an arithmetic model of the counter in the bench. That model is used after trips that are observed one or two cycles late, after undervoltage, and after an external reset in the middle of a discharge.

// File: rtl/ocp_pkg.sv
// Shared types of the over-current protection sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ocp_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_CHARGE    = 2'd0,
        ST_RUN       = 2'd1,
        ST_DISCHARGE = 2'd2,
        ST_LOCKED    = 2'd3
    } seq_state_e;

    // Commands applied to the timing counter
    typedef enum logic [2:0] {
        TMR_HOLD  = 3'd0,
        TMR_UP    = 3'd1,
        TMR_DOWN  = 3'd2,
        TMR_CLEAR = 3'd3,
        TMR_FILL  = 3'd4
    } tmr_cmd_e;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_HI   = 0;
    localparam int SIDE_LO   = 1;

endpackage

// File: rtl/ocp_side_guard.sv
// One side's over-current qualifier: the raw flag is synchronized through two
// flops and accepted only while the side's gate is on and its post-turn-on
// blanking window has expired.
// Assumes: BLANK_CYC >= 1; gate_on is synchronous to clk.
module ocp_side_guard #(
    parameter int BLANK_CYC = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_raw,
    input  logic gate_on,
    output logic oc_accept
);

    localparam int CNT_W = $clog2(BLANK_CYC + 1);
    localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] blank_cnt;
    logic             armed;

    // Two-flop synchronizer for the comparator flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[0], oc_raw};
        end
    end

    // Blanking counter: reloads while the gate is off, counts down while on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_cnt <= BLANK_V;
        end else if (!gate_on) begin
            blank_cnt <= BLANK_V;
        end else if (blank_cnt != '0) begin
            blank_cnt <= blank_cnt - 1'b1;
        end
    end

    // Detection window open only with gate on and blanking expired
    always_comb begin
        armed     = gate_on && (blank_cnt == '0);
        oc_accept = armed && sync_q[1];
    end

    // R4
    accept_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_accept |-> gate_on);

    // R5
    accept_after_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_accept |-> $past(gate_on));

    // R6
    accept_synced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_accept |-> $past(oc_raw, 2));

endmodule

// File: rtl/ocp_cap_timer.sv
// Saturating up/down counter that models the external timing capacitor, with
// lower and upper threshold comparisons.
// Assumes: 1 <= STEP <= FULL_SCALE; LO_TH < HI_TH <= FULL_SCALE.
module ocp_cap_timer
    import ocp_pkg::*;
#(
    parameter int FULL_SCALE = 1000,
    parameter int STEP       = 1,
    parameter int LO_TH      = 300,
    parameter int HI_TH      = 700,
    parameter int TMR_W      = $clog2(FULL_SCALE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_cmd_e         cmd,
    output logic [TMR_W-1:0] tmr,
    output logic             below_lo,
    output logic             at_hi
);

    localparam logic [TMR_W-1:0] FULL_V = TMR_W'(FULL_SCALE);
    localparam logic [TMR_W-1:0] STEP_V = TMR_W'(STEP);
    localparam logic [TMR_W-1:0] LO_V   = TMR_W'(LO_TH);
    localparam logic [TMR_W-1:0] HI_V   = TMR_W'(HI_TH);

    logic [TMR_W-1:0] tmr_inc;
    logic [TMR_W-1:0] tmr_dec;

    // Saturating step values
    always_comb begin
        tmr_inc = (tmr >= FULL_V - STEP_V) ? FULL_V : tmr + STEP_V;
        tmr_dec = (tmr <= STEP_V) ? '0 : tmr - STEP_V;
    end

    // Counter register driven by the sequencer command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= '0;
        end else begin
            unique case (cmd)
                TMR_UP:    tmr <= tmr_inc;
                TMR_DOWN:  tmr <= tmr_dec;
                TMR_CLEAR: tmr <= '0;
                TMR_FILL:  tmr <= FULL_V;
                default:   tmr <= tmr;
            endcase
        end
    end

    // Threshold comparators
    always_comb begin
        below_lo = (tmr < LO_V);
        at_hi    = (tmr >= HI_V);
    end

    // R3
    tmr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr <= FULL_V);

endmodule

// File: rtl/ocp_rst_qual.sv
// Measures how long the external reset request has been held. rst_ok is 1
// once the request has been high for MIN_RST_CYC consecutive edges.
// Assumes: MIN_RST_CYC >= 1.
module ocp_rst_qual #(
    parameter int MIN_RST_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_reset,
    output logic rst_ok
);

    localparam int CNT_W = $clog2(MIN_RST_CYC + 1);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_RST_CYC);

    logic [CNT_W-1:0] hold_cnt;

    // Consecutive-cycle counter, saturating at the minimum width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!ext_reset) begin
            hold_cnt <= '0;
        end else if (hold_cnt != MIN_V) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // Qualified-width flag
    always_comb begin
        rst_ok = (hold_cnt == MIN_V);
    end

    // R8
    qual_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_ok) |-> $past(ext_reset));

endmodule

// File: rtl/ocp_sequencer.sv
// Over-current protection sequencer for a half-bridge gate driver. It combines
// per-side qualified over-current flags, supply undervoltage flags and an
// external request into a global shutdown, using a counter as the timing
// capacitor for the power-up delay, the self-reset and the latched mode.
// Assumes: latch_mode is static while running (it is sampled at reset and on
// every cycle); all inputs except the raw over-current flags are synchronous.
module ocp_sequencer
    import ocp_pkg::*;
#(
    parameter int FULL_SCALE  = 1000,
    parameter int LO_PCT      = 30,
    parameter int HI_PCT      = 70,
    parameter int STEP        = 1,
    parameter int BLANK_CYC   = 45,
    parameter int MIN_RST_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_oc_raw,
    input  logic lo_oc_raw,
    input  logic hi_gate_on,
    input  logic lo_gate_on,
    input  logic uv_logic,
    input  logic uv_drive,
    input  logic latch_mode,
    input  logic ext_reset,
    output logic shutdown,
    output logic prot_status
);

    localparam int LO_TH = FULL_SCALE * LO_PCT / 100;
    localparam int HI_TH = FULL_SCALE * HI_PCT / 100;
    localparam int TMR_W = $clog2(FULL_SCALE + 1);

    logic [NUM_SIDES-1:0] oc_raw_v;
    logic [NUM_SIDES-1:0] gate_v;
    logic [NUM_SIDES-1:0] oc_acc_v;
    logic                 oc_any;
    logic                 uv_any;

    seq_state_e       state_q, state_d;
    logic             latch_q, latch_d;
    tmr_cmd_e         tmr_cmd;
    logic [TMR_W-1:0] tmr_val;
    logic             below_lo;
    logic             at_hi;
    logic             rst_ok;

    // Gather per-side inputs into vectors
    always_comb begin
        oc_raw_v[SIDE_HI] = hi_oc_raw;
        oc_raw_v[SIDE_LO] = lo_oc_raw;
        gate_v[SIDE_HI]   = hi_gate_on;
        gate_v[SIDE_LO]   = lo_gate_on;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        ocp_side_guard #(
            .BLANK_CYC(BLANK_CYC)
        ) u_guard (
            .clk      (clk),
            .rst_n    (rst_n),
            .oc_raw   (oc_raw_v[s]),
            .gate_on  (gate_v[s]),
            .oc_accept(oc_acc_v[s])
        );
    end

    ocp_cap_timer #(
        .FULL_SCALE(FULL_SCALE),
        .STEP      (STEP),
        .LO_TH     (LO_TH),
        .HI_TH     (HI_TH),
        .TMR_W     (TMR_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (tmr_cmd),
        .tmr     (tmr_val),
        .below_lo(below_lo),
        .at_hi   (at_hi)
    );

    ocp_rst_qual #(
        .MIN_RST_CYC(MIN_RST_CYC)
    ) u_rst_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_reset(ext_reset),
        .rst_ok   (rst_ok)
    );

    // Merge fault sources
    always_comb begin
        oc_any = |oc_acc_v;
        uv_any = uv_logic | uv_drive;
    end

    // Sequencer next-state, fault latch and timer command
    always_comb begin
        state_d = state_q;
        latch_d = latch_q;
        tmr_cmd = TMR_HOLD;
        if (uv_any) begin
            state_d = latch_mode ? ST_LOCKED : ST_CHARGE;
            latch_d = 1'b0;
            tmr_cmd = TMR_CLEAR;
        end else if (latch_mode) begin
            if (ext_reset) begin
                state_d = ST_LOCKED;
                tmr_cmd = TMR_CLEAR;
            end else begin
                tmr_cmd = TMR_FILL;
                unique case (state_q)
                    ST_LOCKED: begin
                        if (rst_ok) begin
                            state_d = ST_RUN;
                            latch_d = 1'b0;
                        end
                    end
                    ST_RUN: begin
                        if (oc_any) begin
                            state_d = ST_LOCKED;
                            latch_d = 1'b1;
                        end
                    end
                    default: state_d = ST_LOCKED;
                endcase
            end
        end else if (ext_reset) begin
            state_d = ST_CHARGE;
            latch_d = 1'b0;
            tmr_cmd = TMR_CLEAR;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (oc_any) begin
                        state_d = ST_DISCHARGE;
                        latch_d = 1'b1;
                        tmr_cmd = TMR_DOWN;
                    end else begin
                        tmr_cmd = TMR_UP;
                    end
                end
                ST_DISCHARGE: begin
                    if (below_lo) begin
                        state_d = ST_CHARGE;
                        latch_d = 1'b0;
                        tmr_cmd = TMR_UP;
                    end else begin
                        tmr_cmd = TMR_DOWN;
                    end
                end
                ST_CHARGE: begin
                    tmr_cmd = TMR_UP;
                    if (at_hi) begin
                        state_d = ST_RUN;
                    end
                end
                default: begin
                    state_d = ST_CHARGE;
                    tmr_cmd = TMR_CLEAR;
                end
            endcase
        end
    end

    // State and fault latch registers; reset state depends on the mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= latch_mode ? ST_LOCKED : ST_CHARGE;
            latch_q <= 1'b0;
        end else begin
            state_q <= state_d;
            latch_q <= latch_d;
        end
    end

    // Outputs: gates off unless running with good supplies
    always_comb begin
        shutdown    = (state_q != ST_RUN) | uv_any;
        prot_status = latch_q | (state_q == ST_DISCHARGE);
    end

    // R1
    trip_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RUN && $past(oc_any) && !$past(uv_any) && !$past(ext_reset))
        |-> (latch_q && shutdown));

    // R2
    discharge_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCHARGE && $past(state_q) == ST_DISCHARGE)
        |-> (tmr_val < $past(tmr_val) || tmr_val == '0));

    // R2
    leave_discharge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHARGE && $past(state_q) == ST_DISCHARGE
         && !$past(uv_any) && !$past(ext_reset))
        |-> $past(below_lo));

    // R3
    release_at_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_CHARGE) |-> $past(at_hi));

    // R8
    locked_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_LOCKED)
        |-> ($past(rst_ok) && !$past(ext_reset)));

    // R9
    uv_blocks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uv_any) |-> (state_q != ST_RUN));

endmodule

// File: tb/ocp_sequencer_tb.sv
module ocp_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FULL  = 20;
    localparam int STEP  = 1;
    localparam int BLANK = 4;
    localparam int MINR  = 5;
    localparam int LO    = FULL * 30 / 100;
    localparam int HI    = FULL * 70 / 100;

    logic clk = 1'b0;
    logic rst_n, hi_oc_raw, lo_oc_raw, hi_gate_on, lo_gate_on;
    logic uv_logic, uv_drive, latch_mode, ext_reset;
    logic shutdown, prot_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ocp_sequencer #(
        .FULL_SCALE (FULL),
        .LO_PCT     (30),
        .HI_PCT     (70),
        .STEP       (STEP),
        .BLANK_CYC  (BLANK),
        .MIN_RST_CYC(MINR)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_oc_raw  (hi_oc_raw),
        .lo_oc_raw  (lo_oc_raw),
        .hi_gate_on (hi_gate_on),
        .lo_gate_on (lo_gate_on),
        .uv_logic   (uv_logic),
        .uv_drive   (uv_drive),
        .latch_mode (latch_mode),
        .ext_reset  (ext_reset),
        .shutdown   (shutdown),
        .prot_status(prot_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Model of the counter: edges until normal operation resumes
    function automatic int edges_to_run(input int t0, input bit down0);
        int t = t0;
        bit dn = down0;
        for (int n = 1; n < 10000; n++) begin
            if (dn) begin
                if (t < LO) begin
                    dn = 1'b0;
                    t = (t + STEP > FULL) ? FULL : t + STEP;
                end else begin
                    t = (t < STEP) ? 0 : t - STEP;
                end
            end else begin
                if (t >= HI) return n;
                t = (t + STEP > FULL) ? FULL : t + STEP;
            end
        end
        return -1;
    endfunction

    // Count negedges until shutdown drops; last high sample's status must be 0
    task automatic recover(input int exp, input string req);
        int n = 0;
        logic last_st = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (shutdown) last_st = prot_status;
        end while (shutdown && n < 5000);
        check(n == exp, req, n, exp);
        check(last_st == 1'b0, "R12 status low while charging", int'(last_st), 0);
    endtask

    // Count negedges from gate-on until shutdown appears
    task automatic count_trip(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!shutdown && n < 100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        bit quiet;
        rst_n = 1'b0; hi_oc_raw = 1'b0; lo_oc_raw = 1'b0; hi_gate_on = 1'b0;
        lo_gate_on = 1'b0; uv_logic = 1'b0; uv_drive = 1'b0; latch_mode = 1'b0;
        ext_reset = 1'b0;
        tick(3);
        // R7 reset state
        check(shutdown == 1'b1, "R7 shutdown in reset", int'(shutdown), 1);
        check(prot_status == 1'b0, "R12 status in reset", int'(prot_status), 0);
        rst_n = 1'b1;
        recover(edges_to_run(0, 1'b0), "R7 power-up delay");
        tick(10);
        check(shutdown == 1'b0, "R3 running", int'(shutdown), 0);

        // R5 blanking sweep on both sides (R4 side gating included)
        for (int side = 0; side < 2; side++) begin
            for (int hold = 1; hold <= BLANK + 2; hold++) begin
                if (side == 0) hi_oc_raw = 1'b1; else lo_oc_raw = 1'b1;
                tick(3);
                if (side == 0) hi_gate_on = 1'b1; else lo_gate_on = 1'b1;
                tick(hold);
                hi_gate_on = 1'b0; lo_gate_on = 1'b0;
                hi_oc_raw = 1'b0; lo_oc_raw = 1'b0;
                check(shutdown == (hold >= BLANK + 1), "R5 blanking boundary",
                      int'(shutdown), int'(hold >= BLANK + 1));
                if (hold >= BLANK + 1) begin
                    if (hold == BLANK + 1)
                        check(prot_status == 1'b1, "R12 status after trip", int'(prot_status), 1);
                    recover(edges_to_run(FULL - STEP, 1'b1) - (hold - (BLANK + 1)),
                            "R2 self-reset recovery");
                    tick(10);
                end else begin
                    tick(2);
                    check(shutdown == 1'b0, "R5 short on-time ignored", int'(shutdown), 0);
                end
            end
        end

        // R4 flag of one side with the other side's gate on
        quiet = 1'b1;
        hi_oc_raw = 1'b1; lo_gate_on = 1'b1;
        for (int i = 0; i < 20; i++) begin tick(1); if (shutdown) quiet = 1'b0; end
        check(quiet, "R4 high flag ignored with low gate", int'(quiet), 1);
        lo_gate_on = 1'b0; hi_oc_raw = 1'b0; lo_oc_raw = 1'b1; hi_gate_on = 1'b1;
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin tick(1); if (shutdown) quiet = 1'b0; end
        check(quiet, "R4 low flag ignored with high gate", int'(quiet), 1);
        lo_oc_raw = 1'b0;

        // R6 synchronizer latency (high gate already armed)
        tick(3);
        hi_oc_raw = 1'b1;
        tick(2);
        check(shutdown == 1'b0, "R6 no trip before third edge", int'(shutdown), 0);
        tick(1);
        check(shutdown == 1'b1, "R6 trip at third edge", int'(shutdown), 1);
        check(prot_status == 1'b1, "R1 status on trip", int'(prot_status), 1);
        hi_oc_raw = 1'b0; hi_gate_on = 1'b0;
        recover(edges_to_run(FULL - STEP, 1'b1), "R2 recovery after sync trip");
        tick(10);

        // R11 persistent fault repeats
        lo_oc_raw = 1'b1;
        tick(3);
        for (int rep = 0; rep < 2; rep++) begin
            lo_gate_on = 1'b1;
            count_trip(n);
            check(n == BLANK + 1, "R11 repeated trip time", n, BLANK + 1);
            lo_gate_on = 1'b0;
            recover(edges_to_run(FULL - STEP, 1'b1), "R11 repeated recovery");
            tick(10);
        end
        lo_oc_raw = 1'b0;

        // R10 external request while running
        ext_reset = 1'b1;
        tick(1);
        check(shutdown == 1'b1, "R10 request forces shutdown", int'(shutdown), 1);
        ext_reset = 1'b0;
        recover(edges_to_run(0, 1'b0), "R10 recharge after request");
        tick(10);

        // R10 external request during discharge clears the fault
        hi_oc_raw = 1'b1;
        tick(3);
        hi_gate_on = 1'b1;
        count_trip(n);
        hi_gate_on = 1'b0; hi_oc_raw = 1'b0;
        tick(2);
        check(prot_status == 1'b1, "R12 status while discharging", int'(prot_status), 1);
        ext_reset = 1'b1;
        tick(1);
        check(prot_status == 1'b0, "R10 request clears fault", int'(prot_status), 0);
        ext_reset = 1'b0;
        recover(edges_to_run(0, 1'b0), "R10 recharge after mid-discharge request");
        tick(10);

        // R9 undervoltage on each supply and overlapping
        uv_logic = 1'b1;
        #1;
        check(shutdown == 1'b1, "R9 logic undervoltage immediate", int'(shutdown), 1);
        tick(3);
        uv_logic = 1'b0;
        recover(edges_to_run(0, 1'b0), "R9 restart after logic undervoltage");
        tick(10);
        uv_drive = 1'b1;
        #1;
        check(shutdown == 1'b1, "R9 drive undervoltage immediate", int'(shutdown), 1);
        tick(2);
        uv_logic = 1'b1;
        tick(2);
        uv_drive = 1'b0;
        tick(5);
        check(shutdown == 1'b1, "R9 held while one supply low", int'(shutdown), 1);
        uv_logic = 1'b0;
        recover(edges_to_run(0, 1'b0), "R9 restart after both good");
        tick(10);

        // R8 latched mode
        rst_n = 1'b0; latch_mode = 1'b1;
        tick(2);
        rst_n = 1'b1;
        tick(40);
        check(shutdown == 1'b1, "R8 locked after power-up", int'(shutdown), 1);
        check(prot_status == 1'b0, "R12 status after latched power-up", int'(prot_status), 0);
        for (int w = 1; w <= MINR; w++) begin
            ext_reset = 1'b1;
            tick(w);
            ext_reset = 1'b0;
            tick(2);
            check(shutdown == (w < MINR), "R8 reset pulse width", int'(shutdown), int'(w < MINR));
        end
        ext_reset = 1'b1; tick(1); ext_reset = 1'b0; tick(10);
        check(shutdown == 1'b1, "R8 short pulse while running locks", int'(shutdown), 1);
        ext_reset = 1'b1; tick(MINR + 1); ext_reset = 1'b0; tick(2);
        check(shutdown == 1'b0, "R8 long pulse releases", int'(shutdown), 0);

        hi_oc_raw = 1'b1;
        tick(3);
        hi_gate_on = 1'b1;
        count_trip(n);
        check(n == BLANK + 1, "R1 latched trip time", n, BLANK + 1);
        hi_gate_on = 1'b0; hi_oc_raw = 1'b0;
        tick(100);
        check(shutdown == 1'b1, "R8 stays off after fault", int'(shutdown), 1);
        check(prot_status == 1'b1, "R12 fault held", int'(prot_status), 1);
        ext_reset = 1'b1; tick(MINR - 1); ext_reset = 1'b0; tick(3);
        check(shutdown == 1'b1, "R8 short pulse keeps lock", int'(shutdown), 1);
        check(prot_status == 1'b1, "R8 short pulse keeps fault", int'(prot_status), 1);
        ext_reset = 1'b1; tick(MINR); ext_reset = 1'b0; tick(2);
        check(shutdown == 1'b0, "R8 qualified pulse releases", int'(shutdown), 0);
        check(prot_status == 1'b0, "R12 fault cleared", int'(prot_status), 0);

        uv_drive = 1'b1; tick(3); uv_drive = 1'b0; tick(30);
        check(shutdown == 1'b1, "R9 latched restart needs request", int'(shutdown), 1);
        ext_reset = 1'b1; tick(MINR); ext_reset = 1'b0; tick(2);
        check(shutdown == 1'b0, "R8 release after undervoltage", int'(shutdown), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule